// File: doc/BRIEF.md
# Fractional System Time Counter

This block keeps a 64-bit fixed-point system time that grows by a programmable increment on every cycle of its timing clock. The increment is scaled so that the integer nanosecond count is recovered by shifting the counter right, with no divide. The increment is held in a register that software can rewrite to steer the clock rate. The right-shift amount is published next to the counter.

The block watches a link-speed code. When the effective speed changes, it loads a built-in increment and shift pair for that speed and restarts the count from zero. A build parameter picks between two increment layouts:

- **Wide:** 31 increment bits.
- **Narrow:** 24 increment bits, with a constant period field of 1 placed above them.

In the narrow layout the built-in increments are divided by 128 and the shifts are reduced by 7.

Software uses a small register port to do the following:

- Read the counter as two coherent 32-bit halves.
- Load the counter by writing the low half and then the high half.
- Clear the counter to zero.
- Read and write the increment.
- Read the shift.

Top module: `frac_time_counter`

## Requirements
- R1: While and after reset, `sys_time` is 0. The increment holds the 10G preset: 0x66666666 in the wide layout, 0x00CCCCCC in the narrow one. `ns_shift` is 28 (wide) or 21 (narrow).
- R2: In any cycle without a speed change, load or clear, `sys_time` grows by exactly the current increment and wraps modulo 2^64.
- R3: A write to address 2 replaces the increment from the following cycle on, without altering the accumulated count. The wide layout keeps bits 30:0. The narrow layout keeps bits 23:0. Readback is {1'b0, inc[30:0]} in the wide layout and {8'h01, inc[23:0]} in the narrow one.
- R4: The speed codes are 1 = 100M, 2 = 1G and 3 = 10G. In the wide layout their presets are 0x50000000/21, 0x40000000/24 and 0x66666666/28.
- R5: In the narrow layout each preset increment is the wide one shifted right by 7, and each shift is the wide one minus 7. For example, 1G gives 0x00800000 with shift 17.
- R6: Code 0 (no link) and codes 4 to 7 (unknown) select the 10G preset. Moving between any of these and code 3 is not a change.
- R7: A change of the effective speed sets `sys_time` to 0 and loads that speed's preset at the same edge. An unchanged speed resets nothing.
- R8: Reading address 0 returns the low word and captures the high word at the same edge. A later read of address 1 returns that captured word, even if a carry has since changed the counter.
- R9: A write to address 0 only stages a value and leaves the counter counting. A write to address 1 loads {high, staged low} into the counter at that edge.
- R10: Any write to address 4 sets `sys_time` to 0 at that edge. Counting resumes on the next cycle.
- R11: `time_ns` always equals `sys_time` shifted right by `ns_shift`.
- R12: Read data appears on `reg_rdata` in the cycle after the read strobe. Address 3 returns the shift amount. Unmapped addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| link_code | input | 3 | Link-speed code: 0 none, 1 100M, 2 1G, 3 10G, 4-7 unknown |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| sys_time | output | 64 | Fixed-point system time |
| ns_shift | output | 6 | Right shift that turns `sys_time` into nanoseconds |
| time_ns | output | 64 | Nanosecond view of the counter |

## Verification
A wrong increment shows up within one cycle as a wrong difference between two consecutive `sys_time` samples. It stays visible on every cycle after that, because the error accumulates. A missed or spurious speed change is seen at the very next edge: either `sys_time` fails to drop to zero, or it drops when it should not, and `ns_shift` holds the wrong value. A stale high-word capture is only observable when the capture falls on a carry into the upper half. For that reason the coherent-read test places the low-word read directly on such a carry edge.

// File: rtl/tctr_pkg.sv
package tctr_pkg;

    localparam int REG_W      = 32;
    localparam int TIME_W     = 2 * REG_W;
    localparam int SHIFT_W    = 6;
    localparam int ADDR_W     = 3;
    localparam int NARROW_CUT = 7;

    localparam logic [ADDR_W-1:0] ADDR_TLO = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_THI = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_INC = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_SHF = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CLR = 3'd4;

    typedef enum logic [1:0] {
        SPD_10G  = 2'd0,
        SPD_1G   = 2'd1,
        SPD_100M = 2'd2
    } spd_e;

    typedef struct packed {
        logic [REG_W-1:0]   inc;
        logic [SHIFT_W-1:0] shift;
    } preset_t;

    typedef struct packed {
        logic              ld;
        logic              clr;
        logic [TIME_W-1:0] val;
    } acc_cmd_t;

    // Unknown and absent link both fall back to the fastest rate
    function automatic spd_e speed_decode(input logic [ADDR_W-1:0] code);
        case (code)
            3'd1:    return SPD_100M;
            3'd2:    return SPD_1G;
            default: return SPD_10G;
        endcase
    endfunction

    function automatic preset_t preset_for(input spd_e s, input bit wide);
        preset_t p;
        case (s)
            SPD_100M: begin p.inc = 32'h5000_0000; p.shift = 6'd21; end
            SPD_1G:   begin p.inc = 32'h4000_0000; p.shift = 6'd24; end
            default:  begin p.inc = 32'h6666_6666; p.shift = 6'd28; end
        endcase
        if (!wide) begin
            p.inc   = p.inc >> NARROW_CUT;
            p.shift = p.shift - SHIFT_W'(NARROW_CUT);
        end
        return p;
    endfunction

endpackage

// File: rtl/tctr_speed_track.sv
module tctr_speed_track
    import tctr_pkg::*;
#(
    parameter bit WIDE_INC = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] link_code,
    output logic              spd_chg,
    output preset_t           preset
);
    spd_e eff;
    spd_e cur_q;

    always_comb begin
        eff     = speed_decode(link_code);
        spd_chg = (eff != cur_q);
        preset  = preset_for(eff, WIDE_INC);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= SPD_10G;
        else     cur_q <= eff;
    end

    // R7: one change event per new speed; it does not repeat while the code holds
    spd_settle_chk: assert property (@(posedge clk) disable iff (rst)
        spd_chg |=> (!spd_chg || (link_code != $past(link_code))));

endmodule

// File: rtl/tctr_accum.sv
module tctr_accum
    import tctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spd_chg,
    input  acc_cmd_t          cmd,
    input  logic [REG_W-1:0]  inc,
    output logic [TIME_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (spd_chg) cnt <= '0;
        else if (cmd.ld)  cnt <= cmd.val;
        else if (cmd.clr) cnt <= '0;
        else              cnt <= cnt + TIME_W'(inc);
    end

    // R2
    adv_chk: assert property (@(posedge clk) disable iff (rst)
        (!spd_chg && !cmd.ld && !cmd.clr) |=> (cnt == $past(cnt) + TIME_W'($past(inc))));
    // R7
    spd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        spd_chg |=> (cnt == '0));
    // R9
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.ld && !spd_chg) |=> (cnt == $past(cmd.val)));
    // R10
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr && !cmd.ld) |=> (cnt == '0));

endmodule

// File: rtl/tctr_regif.sv
module tctr_regif
    import tctr_pkg::*;
#(
    parameter bit WIDE_INC = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               spd_chg,
    input  preset_t            preset,
    input  logic [TIME_W-1:0]  cnt,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [REG_W-1:0]   inc_eff,
    output logic [SHIFT_W-1:0] shift,
    output acc_cmd_t           cmd
);
    localparam int              INC_W    = WIDE_INC ? 31 : 24;
    localparam logic [REG_W-1:0] INC_MASK = REG_W'((64'd1 << INC_W) - 64'd1);
    localparam preset_t          RST_PRE  = preset_for(SPD_10G, WIDE_INC);

    logic [REG_W-1:0] inc_q;
    logic [REG_W-1:0] inc_rb;
    logic [REG_W-1:0] stage_lo;
    logic [REG_W-1:0] shadow_hi;

    generate
        if (WIDE_INC) begin : g_wide
            assign inc_rb = inc_q;
        end else begin : g_narrow
            assign inc_rb = inc_q | (REG_W'(1) << INC_W);
        end
    endgenerate

    always_comb begin
        cmd.ld  = reg_wr && (reg_addr == ADDR_THI);
        cmd.clr = reg_wr && (reg_addr == ADDR_CLR);
        cmd.val = {reg_wdata, stage_lo};
        inc_eff = inc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q <= RST_PRE.inc & INC_MASK;
            shift <= RST_PRE.shift;
        end else if (spd_chg) begin
            inc_q <= preset.inc & INC_MASK;
            shift <= preset.shift;
        end else if (reg_wr && (reg_addr == ADDR_INC)) begin
            inc_q <= reg_wdata & INC_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
        end else if (reg_wr && (reg_addr == ADDR_TLO)) begin
            stage_lo <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            shadow_hi <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                ADDR_TLO: begin
                    reg_rdata <= cnt[REG_W-1:0];
                    shadow_hi <= cnt[TIME_W-1:REG_W];
                end
                ADDR_THI: reg_rdata <= shadow_hi;
                ADDR_INC: reg_rdata <= inc_rb;
                ADDR_SHF: reg_rdata <= REG_W'(shift);
                default:  reg_rdata <= '0;
            endcase
        end
    end

    // R3
    inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!spd_chg && !(reg_wr && (reg_addr == ADDR_INC))) |=> $stable(inc_q));
    // R8
    coherent_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (reg_addr == ADDR_THI) && $past(reg_rd && (reg_addr == ADDR_TLO)))
        |=> (reg_rdata == $past(cnt[TIME_W-1:REG_W], 2)));

endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter
    import tctr_pkg::*;
#(
    parameter bit WIDE_INC = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [tctr_pkg::ADDR_W-1:0]  link_code,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [tctr_pkg::ADDR_W-1:0]  reg_addr,
    input  logic [tctr_pkg::REG_W-1:0]   reg_wdata,
    output logic [tctr_pkg::REG_W-1:0]   reg_rdata,
    output logic [tctr_pkg::TIME_W-1:0]  sys_time,
    output logic [tctr_pkg::SHIFT_W-1:0] ns_shift,
    output logic [tctr_pkg::TIME_W-1:0]  time_ns
);
    logic             spd_chg;
    preset_t          preset;
    acc_cmd_t         cmd;
    logic [REG_W-1:0] inc_eff;

    tctr_speed_track #(.WIDE_INC(WIDE_INC)) u_speed (
        .clk       (clk),
        .rst       (rst),
        .link_code (link_code),
        .spd_chg   (spd_chg),
        .preset    (preset)
    );

    tctr_regif #(.WIDE_INC(WIDE_INC)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .spd_chg   (spd_chg),
        .preset    (preset),
        .cnt       (sys_time),
        .reg_rdata (reg_rdata),
        .inc_eff   (inc_eff),
        .shift     (ns_shift),
        .cmd       (cmd)
    );

    tctr_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .spd_chg (spd_chg),
        .cmd     (cmd),
        .inc     (inc_eff),
        .cnt     (sys_time)
    );

    assign time_ns = sys_time >> ns_shift;

endmodule

// File: tb/test_frac_time_counter.sv
`timescale 1ns/1ps
module test_frac_time_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  link_code = 3'd3;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata, reg_rdata_n;
    logic [63:0] sys_time, sys_time_n, time_ns, time_ns_n;
    logic [5:0]  ns_shift, ns_shift_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    frac_time_counter #(.WIDE_INC(1'b1)) i_frac_time_counter (
        .clk(clk), .rst(rst), .link_code(link_code), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_time(sys_time), .ns_shift(ns_shift), .time_ns(time_ns));

    frac_time_counter #(.WIDE_INC(1'b0)) i_frac_time_counter_narrow (
        .clk(clk), .rst(rst), .link_code(link_code), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata_n),
        .sys_time(sys_time_n), .ns_shift(ns_shift_n), .time_ns(time_ns_n));

    typedef struct {
        logic [31:0] exp;
        logic [31:0] exp_n;
        bit          use_n;
        string       tag;
    } item_t;

    item_t sb_q[$];
    bit    rd_pend = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) rd_pend <= reg_rd;
    always @(negedge clk) begin
        if (rd_pend && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            chk(reg_rdata == it.exp, it.tag, 64'(reg_rdata), 64'(it.exp));
            if (it.use_n)
                chk(reg_rdata_n == it.exp_n, {it.tag, " narrow"}, 64'(reg_rdata_n), 64'(it.exp_n));
        end
    end

    task automatic do_read(input logic [2:0] a, input logic [31:0] e, input bit un,
                           input logic [31:0] en, input string tag);
        item_t it;
        it.exp = e; it.exp_n = en; it.use_n = un; it.tag = tag;
        sb_q.push_back(it);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_link(input logic [2:0] c);
        link_code = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] t0, t1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sys_time == 64'd0, "R1 time", sys_time, 64'd0);
        chk(ns_shift == 6'd28, "R1 shift", 64'(ns_shift), 64'd28);
        chk(ns_shift_n == 6'd21, "R1 narrow shift", 64'(ns_shift_n), 64'd21);
        rst = 1'b0;
        // R1 / R5 reset increments
        do_read(3'd2, 32'h6666_6666, 1'b1, 32'h01CC_CCCC, "R1 R5 inc");
        // R12 shift and unmapped
        do_read(3'd3, 32'd28, 1'b1, 32'd21, "R12 shift");
        do_read(3'd7, 32'd0, 1'b0, 32'd0, "R12 unmapped");
        @(negedge clk);

        // R2 accumulation over 5 cycles, R11 nanosecond view
        t0 = sys_time;
        repeat (5) @(negedge clk);
        t1 = sys_time;
        chk(t1 - t0 == 64'd5 * 64'h6666_6666, "R2 delta", t1 - t0, 64'd5 * 64'h6666_6666);
        chk(time_ns == (sys_time >> 28), "R11 ns", time_ns, sys_time >> 28);

        // R3 increment write timing
        t0 = sys_time;
        do_write(3'd2, 32'h0000_0100);
        chk(sys_time == t0 + 64'h6666_6666, "R3 old inc", sys_time, t0 + 64'h6666_6666);
        t0 = sys_time;
        @(negedge clk);
        chk(sys_time == t0 + 64'h100, "R3 new inc", sys_time, t0 + 64'h100);
        do_read(3'd2, 32'h0000_0100, 1'b1, 32'h0100_0100, "R3 readback");
        do_write(3'd2, 32'hFFFF_FFFF);
        do_read(3'd2, 32'h7FFF_FFFF, 1'b1, 32'h01FF_FFFF, "R3 width");
        @(negedge clk);

        // R10 clear
        do_write(3'd4, 32'h0);
        chk(sys_time == 64'd0, "R10 clear", sys_time, 64'd0);
        @(negedge clk);
        chk(sys_time == 64'h7FFF_FFFF, "R10 resume", sys_time, 64'h7FFF_FFFF);

        // R9 load through two halves
        do_write(3'd2, 32'h0000_0010);
        t0 = sys_time;
        do_write(3'd0, 32'hFFFF_FFF0);
        chk(sys_time == t0 + 64'h10, "R9 low only", sys_time, t0 + 64'h10);
        do_write(3'd1, 32'h0000_0005);
        chk(sys_time == 64'h0000_0005_FFFF_FFF0, "R9 load", sys_time, 64'h0000_0005_FFFF_FFF0);
        // R8 coherent read across a carry
        do_read(3'd0, 32'hFFFF_FFF0, 1'b0, 32'd0, "R8 low");
        chk(sys_time[63:32] == 32'd6, "R8 carry", 64'(sys_time[63:32]), 64'd6);
        do_read(3'd1, 32'h0000_0005, 1'b0, 32'd0, "R8 high");
        @(negedge clk);

        // R4 / R5 / R7 speed presets
        set_link(3'd2);
        chk(sys_time == 64'd0, "R7 1G clear", sys_time, 64'd0);
        chk(ns_shift == 6'd24, "R4 1G shift", 64'(ns_shift), 64'd24);
        chk(ns_shift_n == 6'd17, "R5 1G narrow shift", 64'(ns_shift_n), 64'd17);
        @(negedge clk);
        chk(sys_time == 64'h4000_0000, "R4 1G inc", sys_time, 64'h4000_0000);
        do_read(3'd2, 32'h4000_0000, 1'b1, 32'h0180_0000, "R4 R5 1G readback");
        t0 = sys_time;
        repeat (3) @(negedge clk);
        chk(sys_time == t0 + 64'd3 * 64'h4000_0000, "R7 unchanged", sys_time, t0 + 64'd3 * 64'h4000_0000);
        set_link(3'd1);
        chk(sys_time == 64'd0, "R7 100M clear", sys_time, 64'd0);
        chk(ns_shift == 6'd21, "R4 100M shift", 64'(ns_shift), 64'd21);
        @(negedge clk);
        chk(sys_time == 64'h5000_0000, "R4 100M inc", sys_time, 64'h5000_0000);
        set_link(3'd3);
        chk(sys_time == 64'd0 && ns_shift == 6'd28, "R4 10G", {sys_time[57:0], ns_shift}, 64'd28);

        // R6 no link and unknown map to 10G
        t0 = sys_time;
        set_link(3'd0);
        chk(sys_time == t0 + 64'h6666_6666, "R6 none", sys_time, t0 + 64'h6666_6666);
        t0 = sys_time;
        set_link(3'd5);
        chk(sys_time == t0 + 64'h6666_6666, "R6 unknown", sys_time, t0 + 64'h6666_6666);
        set_link(3'd2);
        repeat (2) @(negedge clk);
        set_link(3'd6);
        chk(sys_time == 64'd0, "R6 unknown clear", sys_time, 64'd0);
        chk(ns_shift == 6'd28, "R6 unknown shift", 64'(ns_shift), 64'd28);
        @(negedge clk);
        chk(sys_time == 64'h6666_6666, "R6 unknown inc", sys_time, 64'h6666_6666);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule